// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Automatic Request-to-Send Release

This block serialises characters onto an idle-high line. A character written over a small register bus goes into a holding register. From there it moves into a shift register as soon as the line is free. The transmitter then sends a low start bit, 5 to 8 data bits least significant bit first, an optional parity bit, and a programmable stop period. Transmission is paced by an external tick at sixteen times the bit rate, so a stop period can also last one and a half bit times.

Two mode registers share a single bus address. An internal pointer chooses which of the two an access reaches. A request-to-send output is raised and lowered by command writes. If the automatic-release option is enabled, the transmitter also drops that output by itself exactly one bit time after the last character has completely left the line. This lets a half-duplex link end a message without software having to watch the final stop bit.

Top module: `uart_tx_rts`

## Requirements
- R1: The line idles at 1. Each character starts with one bit at 0, followed by the data bits least significant first. The character-length field in bits 1:0 of mode register 1 selects the data-bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R2: The parity field in bits 4:2 of mode register 1 selects the parity. 000 gives even parity and 001 gives odd parity, each computed over the selected data bits only. Any value with bit 4 set sends no parity bit.
- R3: Parity field 010 always sends a parity bit of 0, and parity field 011 always sends a parity bit of 1, whatever the data.
- R4: The stop field in bits 3:0 of mode register 2 sets how long the line is held at 1 after the character: 16 ticks for value 0, 24 ticks for value 1, and 32 ticks for any other value. Every data bit, start bit and parity bit lasts exactly 16 ticks.
- R5: Address 0 reaches mode register 1 while the pointer is clear. After reset the pointer is clear. Any read or write at address 0 while the pointer is clear sets the pointer. While the pointer is set, accesses at address 0 reach mode register 2 and leave the pointer set. A command write with bit 2 set clears the pointer.
- R6: Both mode registers reset to 0x00 and read back every written bit. Mode register 2 holds channel mode in bits 7:6, automatic RTS release in bit 5, a stored-only CTS control in bit 4, and the stop field in bits 3:0.
- R7: A read at address 1 returns holding-register-empty in bit 0 and transmitter-empty in bit 1. The same two flags are also outputs. Transmitter-empty is 1 only when both the holding register and the shift register are empty.
- R8: A data write at address 1 while the holding register is full is ignored. That character is never sent.
- R9: A command write at address 2 sets RTS when bit 0 is set and clears it when bit 1 is set. A read at address 2 returns RTS in bit 0. RTS is 0 after reset.
- R10: When bit 5 of mode register 2 is set and RTS is 1, RTS falls exactly 16 ticks after the final stop period ends with the holding register empty. This happens once per such drain. With bit 5 clear, RTS is not changed by a drain.
- R11: If a character is waiting in the holding register when a stop period ends, its start bit begins on that same clock edge, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read at address 0 moves the pointer) |
| bus_addr | input | 2 | 0 mode, 1 data and status, 2 command and RTS |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| txd | output | 1 | Serial line |
| rts | output | 1 | Request to send, active high |
| hold_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding and shift registers both empty |

## Verification
The framing is exercised with 8-bit characters without parity, with 5-bit characters under even parity, with 6-bit characters under odd parity, and with 7-bit characters under both forced parity values. These runs use patterns such as 0x13 and 0x0A, chosen so that even and odd parity give different bits, and all-ones or all-zeros data, so that a forced parity bit cannot be mistaken for computed parity. Each stop code is measured at the tick before and at the tick of the end of the frame, which separates one, one and a half and two stop bits. A burst of three writes tests back-to-back framing, rejection of a write to the full holding register and the status flags together. The RTS runs compare the automatic release, the release disabled, and a second assertion after a release that must not be dropped again.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;

  // command bits at ADDR_CMD
  localparam int CMD_RTS_SET = 0;
  localparam int CMD_RTS_CLR = 1;
  localparam int CMD_PTR_RST = 2;

  // parity codes, bit 2 set means no parity bit
  localparam logic [1:0] PAR_EVEN = 2'b00;
  localparam logic [1:0] PAR_ODD  = 2'b01;
  localparam logic [1:0] PAR_LOW  = 2'b10;
  localparam logic [1:0] PAR_HIGH = 2'b11;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;

endpackage

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
  import uart_tx_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [1:0]       len_o,
  output logic [2:0]       par_o,
  output logic [3:0]       stop_o,
  output logic             auto_rts_o,
  output logic             ptr_o,
  output logic             rts_set_o,
  output logic             rts_clr_o,
  output logic [REG_W-1:0] rdata_o
);

  logic             ptr_q, ptr_d;
  logic [REG_W-1:0] mr1_q, mr1_d;
  logic [REG_W-1:0] mr2_q, mr2_d;
  logic             mode_acc, cmd_wr, regs_en;

  assign mode_acc = (bus_wr || bus_rd) && (bus_addr == ADDR_MODE);
  assign cmd_wr   = bus_wr && (bus_addr == ADDR_CMD);
  assign regs_en  = mode_acc || cmd_wr;

  always_comb begin
    ptr_d = ptr_q;
    mr1_d = mr1_q;
    mr2_d = mr2_q;
    if (mode_acc) begin
      if (!ptr_q) begin
        ptr_d = 1'b1;
        if (bus_wr) mr1_d = bus_wdata;
      end else if (bus_wr) begin
        mr2_d = bus_wdata;
      end
    end
    if (cmd_wr && bus_wdata[CMD_PTR_RST]) ptr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= 1'b0;
      mr1_q <= '0;
      mr2_q <= '0;
    end else if (regs_en) begin
      ptr_q <= ptr_d;
      mr1_q <= mr1_d;
      mr2_q <= mr2_d;
    end
  end

  assign len_o      = mr1_q[1:0];
  assign par_o      = mr1_q[4:2];
  assign stop_o     = mr2_q[3:0];
  assign auto_rts_o = mr2_q[5];
  assign ptr_o      = ptr_q;
  assign rts_set_o  = cmd_wr && bus_wdata[CMD_RTS_SET];
  assign rts_clr_o  = cmd_wr && bus_wdata[CMD_RTS_CLR];
  assign rdata_o    = ptr_q ? mr2_q : mr1_q;

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        len_i,
  input  logic [2:0]        par_i,
  input  logic [3:0]        stop_i,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              tx_empty_o,
  output logic              accept_o,
  output logic              drain_o
);

  localparam int SUB_W    = $clog2(2 * OVS);
  localparam int BIT_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;

  localparam logic [SUB_W-1:0] SUB_BIT_END = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] STOP_ONE    = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] STOP_HALF   = SUB_W'(OVS + OVS / 2 - 1);
  localparam logic [SUB_W-1:0] STOP_TWO    = SUB_W'(2 * OVS - 1);

  tx_state_e         state_q, state_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [BIT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              par_acc_q, par_acc_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_full_q, hold_full_d;
  logic [BIT_W-1:0]  f_last_q, f_last_d;
  logic [2:0]        f_par_q, f_par_d;
  logic [SUB_W-1:0]  f_stop_q, f_stop_d;

  logic              bit_end, stop_end, load, accept;
  logic [SUB_W-1:0]  stop_cfg;
  logic              par_bit;

  always_comb begin
    case (stop_i)
      4'd0:    stop_cfg = STOP_ONE;
      4'd1:    stop_cfg = STOP_HALF;
      default: stop_cfg = STOP_TWO;
    endcase
  end

  assign bit_end  = tick_i && (sub_q == SUB_BIT_END);
  assign stop_end = tick_i && (state_q == TX_STOP) && (sub_q == f_stop_q);
  assign load     = hold_full_q && ((state_q == TX_IDLE) || stop_end);
  assign accept   = wr_i && !hold_full_q;

  // holding register side
  always_comb begin
    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    if (accept) begin
      hold_d      = wdata_i;
      hold_full_d = 1'b1;
    end else if (load) begin
      hold_full_d = 1'b0;
    end
  end

  // frame sequencer
  always_comb begin
    state_d   = state_q;
    sub_d     = sub_q;
    bitcnt_d  = bitcnt_q;
    shreg_d   = shreg_q;
    par_acc_d = par_acc_q;
    f_last_d  = f_last_q;
    f_par_d   = f_par_q;
    f_stop_d  = f_stop_q;
    if (tick_i) begin
      case (state_q)
        TX_START: begin
          if (bit_end) begin
            state_d  = TX_DATA;
            sub_d    = '0;
            bitcnt_d = '0;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            sub_d     = '0;
            shreg_d   = shreg_q >> 1;
            par_acc_d = par_acc_q ^ shreg_q[0];
            if (bitcnt_q == f_last_q) begin
              state_d = f_par_q[2] ? TX_STOP : TX_PAR;
            end else begin
              bitcnt_d = bitcnt_q + 1'b1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        TX_PAR: begin
          if (bit_end) begin
            state_d = TX_STOP;
            sub_d   = '0;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        TX_STOP: begin
          if (stop_end) begin
            state_d = TX_IDLE;
            sub_d   = '0;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (load) begin
      state_d   = TX_START;
      sub_d     = '0;
      bitcnt_d  = '0;
      shreg_d   = hold_q;
      par_acc_d = 1'b0;
      f_last_d  = BIT_W'(MIN_BITS - 1) + BIT_W'(len_i);
      f_par_d   = par_i;
      f_stop_d  = stop_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (accept || load) begin
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TX_IDLE;
      sub_q     <= '0;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      par_acc_q <= 1'b0;
      f_last_q  <= '0;
      f_par_q   <= '0;
      f_stop_q  <= '0;
    end else if (tick_i || load) begin
      state_q   <= state_d;
      sub_q     <= sub_d;
      bitcnt_q  <= bitcnt_d;
      shreg_q   <= shreg_d;
      par_acc_q <= par_acc_d;
      f_last_q  <= f_last_d;
      f_par_q   <= f_par_d;
      f_stop_q  <= f_stop_d;
    end
  end

  always_comb begin
    case (f_par_q[1:0])
      PAR_EVEN: par_bit = par_acc_q;
      PAR_ODD:  par_bit = ~par_acc_q;
      PAR_LOW:  par_bit = 1'b0;
      default:  par_bit = 1'b1;
    endcase
  end

  always_comb begin
    case (state_q)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = shreg_q[0];
      TX_PAR:   txd_o = par_bit;
      default:  txd_o = 1'b1;
    endcase
  end

  assign hold_empty_o = !hold_full_q;
  assign tx_empty_o   = (state_q == TX_IDLE) && !hold_full_q;
  assign accept_o     = accept;
  assign drain_o      = stop_end && !hold_full_q;

endmodule

// File: rtl/uart_rts_ctrl.sv
module uart_rts_ctrl #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic auto_en_i,
  input  logic drain_i,
  input  logic cancel_i,
  output logic rts_o
);

  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

  logic             rts_q, rts_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    rts_d   = rts_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (armed_q) begin
      if (cancel_i) begin
        armed_d = 1'b0;
      end else if (tick_i) begin
        if (cnt_q == CNT_LAST) begin
          armed_d = 1'b0;
          rts_d   = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
    if (drain_i && auto_en_i && rts_q) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end
    if (set_i) rts_d = 1'b1;
    if (clr_i) begin
      rts_d   = 1'b0;
      armed_d = 1'b0;
    end
  end

  assign en = armed_q || drain_i || set_i || clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (en) begin
      rts_q   <= rts_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rts_o = rts_q;

endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txd,
  output logic              rts,
  output logic              hold_empty,
  output logic              tx_empty
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_sync;
  logic [1:0]        cfg_len;
  logic [2:0]        cfg_par;
  logic [3:0]        cfg_stop;
  logic              auto_rts;
  logic              mode_ptr;
  logic              rts_set, rts_clr;
  logic [DATA_W-1:0] mode_rdata;
  logic              data_wr;
  logic              accept, drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);

  uart_mode_regs #(.REG_W(DATA_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .len_o      (cfg_len),
    .par_o      (cfg_par),
    .stop_o     (cfg_stop),
    .auto_rts_o (auto_rts),
    .ptr_o      (mode_ptr),
    .rts_set_o  (rts_set),
    .rts_clr_o  (rts_clr),
    .rdata_o    (mode_rdata)
  );

  uart_tx_engine #(.DATA_W(DATA_W), .OVS(OVS)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .tick_i       (tick16),
    .wr_i         (data_wr),
    .wdata_i      (bus_wdata),
    .len_i        (cfg_len),
    .par_i        (cfg_par),
    .stop_i       (cfg_stop),
    .txd_o        (txd),
    .hold_empty_o (hold_empty),
    .tx_empty_o   (tx_empty),
    .accept_o     (accept),
    .drain_o      (drain)
  );

  uart_rts_ctrl #(.OVS(OVS)) u_rts (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .tick_i    (tick16),
    .set_i     (rts_set),
    .clr_i     (rts_clr),
    .auto_en_i (auto_rts),
    .drain_i   (drain),
    .cancel_i  (accept),
    .rts_o     (rts)
  );

  always_comb begin
    case (bus_addr)
      ADDR_MODE: bus_rdata = mode_rdata;
      ADDR_DATA: bus_rdata = {{(DATA_W-2){1'b0}}, tx_empty, hold_empty};
      ADDR_CMD:  bus_rdata = {{(DATA_W-1){1'b0}}, rts};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_tx_rts_chk.sv
module uart_tx_rts_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [2:0] cmd_bits,
  input logic       ptr,
  input logic       auto_en,
  input logic       txd,
  input logic       rts,
  input logic       hold_empty,
  input logic       tx_empty
);

  logic mode_acc, cmd_wr;
  assign mode_acc = (bus_wr || bus_rd) && (bus_addr == 2'd0);
  assign cmd_wr   = bus_wr && (bus_addr == 2'd2);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  assert_empty_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  assert_ptr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_acc && !ptr) |=> ptr);

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_acc && ptr) |=> ptr);

  assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_bits[2]) |=> !ptr);

  assert_rts_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_bits[0] && !cmd_bits[1]) |=> rts);

  assert_rts_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> ($past(cmd_wr && cmd_bits[1]) || $past(auto_en)));

endmodule

bind uart_tx_rts uart_tx_rts_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .cmd_bits   (bus_wdata[2:0]),
  .ptr        (mode_ptr),
  .auto_en    (auto_rts),
  .txd        (txd),
  .rts        (rts),
  .hold_empty (hold_empty),
  .tx_empty   (tx_empty)
);

// File: tb/uart_tx_rts_tb.sv
module uart_tx_rts_tb;

  logic       clk;
  logic       rst_n;
  logic       tick16;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       txd, rts, hold_empty, tx_empty;

  int nchecks = 0;
  int nerrs   = 0;
  int tcount  = 0;

  typedef struct {
    logic [7:0] data;
    int         nb;
    logic [2:0] par;
    int         stop16;
  } frame_t;
  frame_t exp_q[$];

  int         cur_nb     = 8;
  logic [2:0] cur_par    = 3'b000;
  int         cur_stop16 = 16;

  uart_tx_rts u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rts(rts), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial tick16 = 1'b0;
  always @(posedge clk) tick16 <= !tick16;
  always @(posedge clk) if (tick16) tcount <= tcount + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_tc(input int v);
    while (tcount < v) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic configure(input logic [7:0] m1, input logic [7:0] m2);
    bus_write(2'd2, 8'h04);
    bus_write(2'd0, m1);
    bus_write(2'd0, m2);
    cur_nb  = 5 + int'(m1[1:0]);
    cur_par = m1[4:2];
    cur_stop16 = (m2[3:0] == 4'd0) ? 16 : (m2[3:0] == 4'd1) ? 24 : 32;
  endtask

  task automatic send(input logic [7:0] d, input bit expect_it);
    frame_t f;
    if (expect_it) begin
      f.data = d; f.nb = cur_nb; f.par = cur_par; f.stop16 = cur_stop16;
      exp_q.push_back(f);
    end
    bus_write(2'd1, d);
  endtask

  task automatic wait_drain(output int t_end);
    repeat (2) @(negedge clk);
    while (!tx_empty) @(negedge clk);
    t_end = tcount;
  endtask

  function automatic logic exp_parity(input frame_t f);
    int ones = 0;
    for (int k = 0; k < f.nb; k++) ones += int'(f.data[k]);
    case (f.par[1:0])
      2'b00:   return logic'(ones % 2);
      2'b01:   return !logic'(ones % 2);
      2'b10:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // monitor: pops expected frames and compares the line bit by bit
  initial begin
    bit skip = 0;
    wait (rst_n === 1'b1);
    forever begin
      if (!skip) @(negedge clk);
      skip = 0;
      if (txd === 1'b0) begin
        int t0, p, len;
        frame_t f;
        t0 = tcount;
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected frame on line", 1, 0);
          while (!tx_empty) @(negedge clk);
        end else begin
          f = exp_q.pop_front();
          p = f.par[2] ? 0 : 1;
          len = 16 * (1 + f.nb + p) + f.stop16;
          wait_tc(t0 + 8);
          check(txd == 1'b0, "R1", "start bit", int'(txd), 0);
          for (int k = 0; k < f.nb; k++) begin
            wait_tc(t0 + 8 + 16 * (k + 1));
            check(txd == f.data[k], "R1", $sformatf("data bit %0d", k),
                  int'(txd), int'(f.data[k]));
          end
          if (p == 1) begin
            wait_tc(t0 + 8 + 16 * (1 + f.nb));
            check(txd == exp_parity(f), f.par[1] ? "R3" : "R2", "parity bit",
                  int'(txd), int'(exp_parity(f)));
          end
          wait_tc(t0 + 16 * (1 + f.nb + p) + 4);
          check(txd == 1'b1, "R4", "stop level", int'(txd), 1);
          wait_tc(t0 + len - 1);
          check(txd == 1'b1 && !tx_empty, "R4", "stop not yet over",
                int'({tx_empty, txd}), 1);
          wait_tc(t0 + len);
          check(txd == 1'b0 || tx_empty, (exp_q.size() > 0) ? "R11" : "R4",
                "frame end at exact tick", int'({tx_empty, txd}), 2);
          skip = 1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerrs++;
    nchecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int t_end;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(txd == 1'b1, "R1", "reset line idle", int'(txd), 1);
    check(rts == 1'b0, "R9", "reset rts", int'(rts), 0);
    check(hold_empty && tx_empty, "R7", "reset status flags",
          int'({tx_empty, hold_empty}), 3);
    bus_read(2'd0, rd); check(rd == 8'h00, "R6", "reset mode register 1", rd, 0);
    bus_read(2'd0, rd); check(rd == 8'h00, "R6", "reset mode register 2", rd, 0);

    // pointer and readback
    bus_write(2'd2, 8'h04);
    bus_write(2'd0, 8'hE6);
    bus_write(2'd0, 8'hD5);
    bus_write(2'd2, 8'h04);
    bus_read(2'd0, rd); check(rd == 8'hE6, "R5", "first access reaches register 1", rd, 8'hE6);
    bus_read(2'd0, rd); check(rd == 8'hD5, "R6", "register 2 readback", rd, 8'hD5);
    bus_read(2'd0, rd); check(rd == 8'hD5, "R5", "pointer stays on register 2", rd, 8'hD5);

    // 8 data bits, no parity, one stop
    configure(8'h13, 8'h00);
    send(8'hA5, 1); wait_drain(t_end);
    send(8'h3C, 1); wait_drain(t_end);

    // 5 data bits, even parity, stop code 2
    configure(8'h00, 8'h02);
    send(8'h13, 1); wait_drain(t_end);
    send(8'h0A, 1); wait_drain(t_end);

    // 6 data bits, odd parity, one and a half stop
    configure(8'h05, 8'h01);
    send(8'h2D, 1); wait_drain(t_end);
    send(8'h13, 1); wait_drain(t_end);

    // 7 data bits, forced parity, stop code 5
    configure(8'h0A, 8'h05);
    send(8'h7F, 1); wait_drain(t_end);
    configure(8'h0E, 8'h05);
    send(8'h00, 1); wait_drain(t_end);

    // back to back, ignored write, status
    configure(8'h13, 8'h00);
    send(8'h81, 1);
    @(negedge clk);
    send(8'h42, 1);
    send(8'hFF, 0);
    check(hold_empty == 1'b0, "R7", "holding register full", int'(hold_empty), 0);
    bus_read(2'd1, rd); check(rd == 8'h00, "R7", "status while busy", rd, 0);
    wait_drain(t_end);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R8", "write to full holding register dropped",
          exp_q.size(), 0);
    bus_read(2'd1, rd); check(rd == 8'h03, "R7", "status after drain", rd, 3);

    // automatic RTS release
    configure(8'h13, 8'h20);
    bus_write(2'd2, 8'h01);
    bus_read(2'd2, rd); check(rd == 8'h01, "R9", "rts readback set", rd, 1);
    send(8'h5A, 1);
    wait_drain(t_end);
    wait_tc(t_end + 15);
    check(rts == 1'b1, "R10", "rts held until one bit time", int'(rts), 1);
    wait_tc(t_end + 16);
    check(rts == 1'b0, "R10", "rts released after one bit time", int'(rts), 0);
    bus_write(2'd2, 8'h01);
    wait_tc(tcount + 40);
    check(rts == 1'b1, "R10", "release fires once per drain", int'(rts), 1);

    // release disabled
    configure(8'h13, 8'h00);
    send(8'hC3, 1);
    wait_drain(t_end);
    wait_tc(t_end + 40);
    check(rts == 1'b1, "R10", "no release when disabled", int'(rts), 1);
    bus_write(2'd2, 8'h02);
    bus_read(2'd2, rd); check(rd == 8'h00, "R9", "rts cleared by command", rd, 0);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R1", "all frames seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

endmodule